// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine walks a ring of receive descriptors held in a small internal descriptor memory, one packet at a time. Each descriptor takes four 16-bit words: a status word, a header word and two buffer-pointer words. When a packet starts, the engine reads the status word of the current descriptor. If the engine owns that descriptor, it writes the first header byte into the status word and the remaining two header bytes into the header word. When the packet ends, it closes the descriptor and moves the ring index to the next descriptor. A host port reads and writes the same memory to prepare descriptors and to collect results.

Packet-side errors, header-check failures and packets that find no free buffer are reported as entries in a small event FIFO, which the host drains. A one-cycle interrupt pulse marks each serviced descriptor that requested an interrupt, provided the queue-level enable is set. Moving payload bytes and computing the header check are out of scope: the check result arrives as a flag together with packet start.

Top module: `rx_ring_engine`

## Requirements
- R1: Status word bits, numbered from the MSB: [15] owned-by-engine (E), [14] continuous (CM), [13] last-in-ring (W), [12] interrupt request (I), [11:9] reserved, [8] incomplete (UP), [7:0] first header byte. Word offset 0 is status, 1 is header bytes 2..3, and 2 and 3 are the buffer pointer. When a packet is accepted, the status word takes pkt_hdr_i[23:16] with E still set, UP clear and the reserved bits clear, and word 1 takes pkt_hdr_i[15:0].
- R2: A packet that starts while the current descriptor has E=0 (with discard mode off) leaves that descriptor unchanged, pushes event {4'h2, pkt_hdr_i[23:16]} and does not advance the ring index.
- R3: On a normal close (pkt_end_i), E is cleared when CM=0 and kept set when CM=1, and UP stays clear.
- R4: On an error close (pkt_err_i), E is cleared whatever CM holds, UP is set, and event {2'b10, err_code_i, cid} is pushed, where cid is the first header byte.
- R5: After a descriptor with W=1 is closed, the next packet uses descriptor 0.
- R6: After the last descriptor (index NUM_DESC-1) is closed, the index returns to 0 even if its W=0.
- R7: irq_o pulses high for exactly the one cycle after a close, and only when the closed descriptor has I=1 and rbm_en_i=1.
- R8: A packet that starts with hec_err_i=1 pushes event {4'h1, 8'h00} and writes no descriptor.
- R9: The engine never writes the buffer-pointer words (offsets 2 and 3).
- R10: With ppd_en_i=1 and the current descriptor not owned, the frame is dropped silently: no event, no descriptor write, no index change.
- R11: Host reads are granted at once. A host write is held off (host_gnt_o=0) in any cycle in which the engine writes, and the engine's write always goes ahead.
- R12: Events leave the FIFO in arrival order. A push to a full FIFO (EVT_DEPTH entries) is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rbm_en_i | input | 1 | Queue-level interrupt enable |
| ppd_en_i | input | 1 | Silent discard when no buffer is free |
| pkt_start_i | input | 1 | Packet start strobe, header valid |
| pkt_hdr_i | input | 24 | Packet header, channel ID in [23:16] |
| hec_err_i | input | 1 | Header check failed, qualified by start |
| pkt_end_i | input | 1 | Packet completed normally |
| pkt_err_i | input | 1 | Packet aborted with an error |
| err_code_i | input | 2 | Error type, qualified by pkt_err_i |
| host_req_i | input | 1 | Host memory access request |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | clog2(NUM_DESC)+2 | Host word address {index, offset} |
| host_wdata_i | input | 16 | Host write data |
| host_gnt_o | output | 1 | Host access takes effect this cycle |
| host_rdata_o | output | 16 | Host read data, combinational |
| irq_o | output | 1 | Serviced-descriptor interrupt pulse |
| evt_valid_o | output | 1 | Event FIFO not empty |
| evt_data_o | output | 12 | Head event {code[3:0], cid[7:0]} |
| evt_pop_i | input | 1 | Remove the head event |

## Verification
The assertions assume that a packet-side source obeys framing: pkt_end_i or pkt_err_i arrives at least two cycles after pkt_start_i and never together with it. They also assume the host does not rewrite a status word while the engine owns it. The bench keeps to this by spacing every frame as start, one idle cycle, then end or error. It edits descriptors only between frames, except for the one deliberate write issued during a frame to force a collision, and that write targets a pointer word the engine never touches.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned E_B  = 15;
  localparam int unsigned CM_B = 14;
  localparam int unsigned W_B  = 13;
  localparam int unsigned I_B  = 12;
  localparam int unsigned UP_B = 8;

  localparam logic [3:0] EV_HEC  = 4'h1;
  localparam logic [3:0] EV_BUSY = 4'h2;
  localparam logic [1:0] EV_RXERR_HI = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_RECV, ST_DROP} eng_st_e;
endpackage

// File: rtl/rx_desc_mem.sv
module rx_desc_mem #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/rx_evt_fifo.sv
module rx_evt_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 12,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] buf_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign do_push = push_i && (cnt_q != CW'(DEPTH));  // full: drop new entry

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      if (do_push) begin
        buf_q[wr_q] <= push_data_i;
        wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = buf_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int unsigned NUM_DESC = 8,
  localparam int unsigned IW = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int unsigned AW = IW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rbm_en_i,
  input  logic          ppd_en_i,
  input  logic          pkt_start_i,
  input  logic [23:0]   pkt_hdr_i,
  input  logic          hec_err_i,
  input  logic          pkt_end_i,
  input  logic          pkt_err_i,
  input  logic [1:0]    err_code_i,
  input  logic [15:0]   stat_i,
  output logic [AW-1:0] stat_addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [15:0]   wdata_o,
  output logic          push_o,
  output logic [11:0]   push_data_o,
  output logic          irq_o,
  output eng_st_e       state_o
);
  eng_st_e       st_q, st_d;
  logic [IW-1:0] idx_q;
  logic [23:0]   hdr_q;
  logic          irq_q;
  logic          close, done;
  logic [3:0]    unused_stat;

  assign unused_stat = stat_i[11:8];
  assign done        = pkt_end_i || pkt_err_i;
  assign stat_addr_o = {idx_q, 2'd0};

  always_comb begin
    st_d        = st_q;
    we_o        = 1'b0;
    waddr_o     = {idx_q, 2'd0};
    wdata_o     = stat_i;
    push_o      = 1'b0;
    push_data_o = '0;
    close       = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pkt_start_i) begin
        if (hec_err_i) begin
          push_o      = 1'b1;
          push_data_o = {EV_HEC, 8'h00};
          st_d        = ST_DROP;
        end else if (stat_i[E_B]) begin
          we_o    = 1'b1;
          wdata_o = {1'b1, stat_i[CM_B], stat_i[W_B], stat_i[I_B], 3'b000, 1'b0,
                     pkt_hdr_i[23:16]};
          st_d    = ST_HDR;
        end else begin
          push_o      = !ppd_en_i;
          push_data_o = {EV_BUSY, pkt_hdr_i[23:16]};
          st_d        = ST_DROP;
        end
      end
      ST_HDR: begin
        we_o    = 1'b1;
        waddr_o = {idx_q, 2'd1};
        wdata_o = hdr_q[15:0];
        st_d    = ST_RECV;
      end
      ST_RECV: if (done) begin
        close   = 1'b1;
        we_o    = 1'b1;
        // error overrides continuous mode
        wdata_o = {!pkt_err_i && stat_i[CM_B], stat_i[CM_B], stat_i[W_B], stat_i[I_B],
                   3'b000, pkt_err_i, stat_i[7:0]};
        push_o      = pkt_err_i;
        push_data_o = {EV_RXERR_HI, err_code_i, hdr_q[23:16]};
        st_d        = ST_IDLE;
      end
      ST_DROP: if (done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      hdr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= close && stat_i[I_B] && rbm_en_i;
      if (st_q == ST_IDLE && pkt_start_i) hdr_q <= pkt_hdr_i;
      if (close) begin
        if (stat_i[W_B] || idx_q == IW'(NUM_DESC - 1)) idx_q <= '0;
        else idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign irq_o   = irq_q;
  assign state_o = st_q;
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int unsigned NUM_DESC  = 8,
  parameter int unsigned EVT_DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rbm_en_i,
  input  logic                          ppd_en_i,
  input  logic                          pkt_start_i,
  input  logic [23:0]                   pkt_hdr_i,
  input  logic                          hec_err_i,
  input  logic                          pkt_end_i,
  input  logic                          pkt_err_i,
  input  logic [1:0]                    err_code_i,
  input  logic                          host_req_i,
  input  logic                          host_we_i,
  input  logic [$clog2(NUM_DESC)+1:0]   host_addr_i,
  input  logic [15:0]                   host_wdata_i,
  output logic                          host_gnt_o,
  output logic [15:0]                   host_rdata_o,
  output logic                          irq_o,
  output logic                          evt_valid_o,
  output logic [11:0]                   evt_data_o,
  input  logic                          evt_pop_i
);
  localparam int unsigned AW    = $clog2(NUM_DESC) + 2;
  localparam int unsigned WORDS = NUM_DESC * 4;
  localparam int unsigned CW    = $clog2(EVT_DEPTH + 1);

  logic          eng_we, mem_we, push;
  logic [AW-1:0] eng_waddr, stat_addr, mem_waddr;
  logic [15:0]   eng_wdata, mem_wdata, stat_rd;
  logic [11:0]   push_data;
  logic [CW-1:0] evt_cnt;
  eng_st_e       eng_st;

  rx_ring_ctrl #(.NUM_DESC(NUM_DESC)) u_ctrl (
    .clk_i, .rst_ni, .rbm_en_i, .ppd_en_i, .pkt_start_i, .pkt_hdr_i, .hec_err_i,
    .pkt_end_i, .pkt_err_i, .err_code_i,
    .stat_i(stat_rd), .stat_addr_o(stat_addr),
    .we_o(eng_we), .waddr_o(eng_waddr), .wdata_o(eng_wdata),
    .push_o(push), .push_data_o(push_data), .irq_o, .state_o(eng_st)
  );

  // engine has fixed priority on the single write port
  assign host_gnt_o = host_req_i && !(host_we_i && eng_we);
  assign mem_we     = eng_we || (host_gnt_o && host_we_i);
  assign mem_waddr  = eng_we ? eng_waddr : host_addr_i;
  assign mem_wdata  = eng_we ? eng_wdata : host_wdata_i;

  rx_desc_mem #(.DEPTH(WORDS), .DW(16)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_a_i(stat_addr), .rdata_a_o(stat_rd),
    .raddr_b_i(host_addr_i), .rdata_b_o(host_rdata_o)
  );

  rx_evt_fifo #(.DEPTH(EVT_DEPTH), .DW(12)) u_evt (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(push_data), .pop_i(evt_pop_i),
    .valid_o(evt_valid_o), .data_o(evt_data_o), .count_o(evt_cnt)
  );
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk
  import rx_ring_pkg::*;
#(
  parameter int unsigned NUM_DESC  = 8,
  parameter int unsigned EVT_DEPTH = 4,
  localparam int unsigned AW = $clog2(NUM_DESC) + 2,
  localparam int unsigned CW = $clog2(EVT_DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          host_req_i,
  input logic          host_we_i,
  input logic          host_gnt_o,
  input logic          pkt_err_i,
  input logic          pkt_start_i,
  input logic          hec_err_i,
  input logic          eng_we,
  input logic [AW-1:0] eng_waddr,
  input logic [15:0]   eng_wdata,
  input logic [CW-1:0] evt_cnt,
  input eng_st_e       eng_st
);
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_host_rd_gnt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_req_i && !host_we_i) |-> host_gnt_o);

  p_host_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_gnt_o && host_we_i) |-> !eng_we);

  p_ptr_untouched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_we |-> (eng_waddr[1] == 1'b0));

  p_err_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_st == ST_RECV && pkt_err_i) |-> (eng_we && !eng_wdata[E_B] && eng_wdata[UP_B]));

  p_hec_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_st == ST_IDLE && pkt_start_i && hec_err_i) |-> !eng_we);

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_cnt <= CW'(EVT_DEPTH));
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.NUM_DESC(NUM_DESC), .EVT_DEPTH(EVT_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .host_req_i(host_req_i),
  .host_we_i(host_we_i), .host_gnt_o(host_gnt_o), .pkt_err_i(pkt_err_i),
  .pkt_start_i(pkt_start_i), .hec_err_i(hec_err_i), .eng_we(eng_we),
  .eng_waddr(eng_waddr), .eng_wdata(eng_wdata), .evt_cnt(evt_cnt), .eng_st(eng_st)
);

// File: tb/rx_ring_engine_tb.sv
module rx_ring_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DESC   = 8;
  localparam int EVT_DEPTH  = 4;
  localparam int AW         = $clog2(NUM_DESC) + 2;

  // {cm, i, err, ecode[1:0], 3'b0, hdr[23:0]}
  localparam logic [31:0] VEC [4] = '{
    {1'b0, 1'b1, 1'b0, 2'd0, 3'b0, 24'h1A2345},
    {1'b1, 1'b0, 1'b0, 2'd0, 3'b0, 24'h2B3456},
    {1'b1, 1'b1, 1'b1, 2'd2, 3'b0, 24'h3C4567},
    {1'b0, 1'b1, 1'b0, 2'd0, 3'b0, 24'h4D5678}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic rbm_en = 1'b1, ppd_en = 1'b0;
  logic pkt_start = 1'b0, hec_err = 1'b0, pkt_end = 1'b0, pkt_err = 1'b0;
  logic [23:0] pkt_hdr = '0;
  logic [1:0]  err_code = '0;
  logic host_req = 1'b0, host_we = 1'b0, evt_pop = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic host_gnt, irq, evt_valid;
  logic [11:0] evt_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_engine #(.NUM_DESC(NUM_DESC), .EVT_DEPTH(EVT_DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rbm_en_i(rbm_en), .ppd_en_i(ppd_en),
    .pkt_start_i(pkt_start), .pkt_hdr_i(pkt_hdr), .hec_err_i(hec_err),
    .pkt_end_i(pkt_end), .pkt_err_i(pkt_err), .err_code_i(err_code),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_gnt_o(host_gnt), .host_rdata_o(host_rdata),
    .irq_o(irq), .evt_valid_o(evt_valid), .evt_data_o(evt_data), .evt_pop_i(evt_pop)
  );

  function automatic logic [15:0] st(input logic e, cm, w, i, up, input logic [7:0] b);
    return {e, cm, w, i, 3'b000, up, b};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input int d, input int off, input logic [15:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(d * 4 + off); host_wdata = v;
    #1;
    while (!host_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input int d, input int off, output logic [15:0] v);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = AW'(d * 4 + off);
    #1;
    v = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic send_pkt(input logic [23:0] h, input logic hec, err, input logic [1:0] ec);
    @(negedge clk); pkt_start = 1'b1; pkt_hdr = h; hec_err = hec;
    @(negedge clk); pkt_start = 1'b0; hec_err = 1'b0;
    @(negedge clk);
    if (err) begin pkt_err = 1'b1; err_code = ec; end
    else pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0; pkt_err = 1'b0;
  endtask

  task automatic pop_evt(output logic v, output logic [11:0] d);
    @(negedge clk);
    v = evt_valid; d = evt_data;
    evt_pop = v;
    @(negedge clk);
    evt_pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic v;
    logic [11:0] ev;

    do_reset();
    // reset state
    chk(!irq && !evt_valid, "reset irq/evt", {irq, evt_valid}, 0);
    host_rd(0, 0, rd);
    chk(rd == 16'h0, "reset mem R11", rd, 0);

    for (int d = 0; d < 4; d++) begin
      host_wr(d, 2, 16'hA000 + 16'(d));
      host_wr(d, 3, 16'hB000 + 16'(d));
    end

    // vector table: R1 R3 R4 R7
    rbm_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic cm, ii, er;
      logic [1:0] ec;
      logic [23:0] h;
      {cm, ii, er, ec} = VEC[k][31:27];
      h = VEC[k][23:0];
      host_wr(k, 0, st(1'b1, cm, k == 3, ii, 1'b0, 8'h00));
      send_pkt(h, 1'b0, er, ec);
      chk(irq == ii, "R7 irq after close", irq, ii);
      host_rd(k, 0, rd);
      chk(rd == st(!er && cm, cm, k == 3, ii, er, h[23:16]), er ? "R4 status" : "R3 status",
          rd, st(!er && cm, cm, k == 3, ii, er, h[23:16]));
      host_rd(k, 1, rd);
      chk(rd == h[15:0], "R1 header word", rd, h[15:0]);
      if (er) begin
        pop_evt(v, ev);
        chk(v && ev == {2'b10, ec, h[23:16]}, "R4 error event", {v, ev}, {1'b1, 2'b10, ec, h[23:16]});
      end
    end
    chk(!evt_valid, "R3 no event on normal close", evt_valid, 0);

    // R5: wrap after W
    host_wr(0, 0, st(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    send_pkt(24'h5A0102, 1'b0, 1'b0, 2'd0);
    host_rd(0, 0, rd);
    chk(rd == st(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A), "R5 wrap to desc0", rd,
        st(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A));

    // R2: not owned, discard off
    ppd_en = 1'b0;
    host_wr(1, 0, 16'h0011);
    send_pkt(24'h5E0000, 1'b0, 1'b0, 2'd0);
    host_rd(1, 0, rd);
    chk(rd == 16'h0011, "R2 desc unchanged", rd, 16'h0011);
    pop_evt(v, ev);
    chk(v && ev == 12'h25E, "R2 busy event", {v, ev}, {1'b1, 12'h25E});
    host_wr(1, 0, st(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    send_pkt(24'h6F0000, 1'b0, 1'b0, 2'd0);
    host_rd(1, 0, rd);
    chk(rd[7:0] == 8'h6F, "R2 index not advanced", rd[7:0], 8'h6F);

    // R10: silent discard (desc2 E=0 after error close)
    ppd_en = 1'b1;
    send_pkt(24'h710000, 1'b0, 1'b0, 2'd0);
    chk(!evt_valid, "R10 no event", evt_valid, 0);
    host_rd(2, 0, rd);
    chk(rd[7:0] == 8'h3C && !rd[15], "R10 desc unchanged", rd, 16'h0);
    ppd_en = 1'b0;

    // R8: header check error
    host_wr(2, 0, st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00));
    send_pkt(24'h770000, 1'b1, 1'b0, 2'd0);
    pop_evt(v, ev);
    chk(v && ev == 12'h100, "R8 hec event cid 0", {v, ev}, {1'b1, 12'h100});
    host_rd(2, 0, rd);
    chk(rd == st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00), "R8 no desc write", rd,
        st(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00));

    // R7: queue enable off suppresses irq
    rbm_en = 1'b0;
    send_pkt(24'h780000, 1'b0, 1'b0, 2'd0);
    chk(!irq, "R7 rbm off no irq", irq, 0);
    host_rd(2, 0, rd);
    chk(rd[7:0] == 8'h78, "R7 desc2 used", rd[7:0], 8'h78);
    rbm_en = 1'b1;

    // R9: pointer words intact
    for (int d = 0; d < 4; d++) begin
      host_rd(d, 2, rd);
      chk(rd == 16'hA000 + 16'(d), "R9 ptr hi", rd, 16'hA000 + 16'(d));
      host_rd(d, 3, rd);
      chk(rd == 16'hB000 + 16'(d), "R9 ptr lo", rd, 16'hB000 + 16'(d));
    end

    // R12: five busy events into four slots (desc3 E=0)
    for (int k = 0; k < 5; k++) send_pkt({8'hC0 + 8'(k), 16'h0}, 1'b0, 1'b0, 2'd0);
    for (int k = 0; k < EVT_DEPTH; k++) begin
      pop_evt(v, ev);
      chk(v && ev == {4'h2, 8'hC0 + 8'(k)}, "R12 fifo order", {v, ev}, {1'b1, 4'h2, 8'hC0 + 8'(k)});
    end
    chk(!evt_valid, "R12 overflow dropped", evt_valid, 0);

    // R11: host write collides with engine writes
    do_reset();
    host_wr(0, 0, st(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    @(negedge clk);
    pkt_start = 1'b1; pkt_hdr = 24'h8899AA;
    host_req = 1'b1; host_we = 1'b1; host_addr = AW'(5 * 4 + 2); host_wdata = 16'h1234;
    #1;
    chk(!host_gnt, "R11 held on start write", host_gnt, 0);
    @(negedge clk); pkt_start = 1'b0; #1;
    chk(!host_gnt, "R11 held on header write", host_gnt, 0);
    @(negedge clk); #1;
    chk(host_gnt, "R11 granted when engine idle", host_gnt, 1);
    @(negedge clk); host_req = 1'b0; host_we = 1'b0; pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
    host_rd(5, 2, rd);
    chk(rd == 16'h1234, "R11 held write landed", rd, 16'h1234);
    host_rd(0, 1, rd);
    chk(rd == 16'h99AA, "R11 engine write intact", rd, 16'h99AA);

    // R6: no W bit, wrap at NUM_DESC (index now 1)
    do_reset();
    for (int d = 0; d < NUM_DESC; d++) host_wr(d, 0, st(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00));
    for (int k = 0; k <= NUM_DESC; k++) send_pkt({8'h80 + 8'(k), 16'h0}, 1'b0, 1'b0, 2'd0);
    host_rd(0, 0, rd);
    chk(rd == st(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80 + 8'(NUM_DESC)), "R6 wrap w/o W", rd,
        st(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h80 + 8'(NUM_DESC)));
    host_rd(NUM_DESC - 1, 0, rd);
    chk(rd[7:0] == 8'h80 + 8'(NUM_DESC - 1), "R6 last desc used", rd[7:0], 8'h80 + 8'(NUM_DESC - 1));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule